// File: doc/BRIEF.md
# Byte-Bus Word-Read Cache Adapter

This block sits between a 16-bit core datapath and an 8-bit external memory bus and serves read requests only. A core request carries a 24-bit address and a size flag. A word request is split into two single-byte accesses. The first uses the requested address and the second uses that address plus one. Each byte is looked up separately in a small direct-mapped cache. The cache keeps one valid bit per byte, so a word can be served fully from the cache, partly from the cache, or fully from the bus.

A cache miss runs one external byte transaction. The address is driven first, then the address strobe, then the read strobe. Data is taken on the cycle in which the bus signals ready. The fetched byte fills only its own cache location. A cache-enable input makes every byte go to the bus. A flush input clears every valid bit in one cycle.

Top module: `byte_word_rcache`

## Requirements
- R1: A word request that misses on both bytes produces exactly two bus transactions. The first uses the requested address and the second uses the requested address plus one.
- R2: In a word response, `rsp_data[7:0]` holds the byte from the requested address and `rsp_data[15:8]` holds the byte from the address plus one.
- R3: A completed bus transaction writes the byte sampled from `bus_din` into that address's cache location and marks only that byte valid. A neighbouring byte in the same line stays invalid and still needs its own bus transaction.
- R4: A byte that is valid in the cache with a matching tag is returned from the cache, and `bus_as` stays low for it.
- R5: While `cache_en` is 0, every byte access goes to the bus and no fill takes place. When the cache is enabled again, those bytes still miss.
- R6: Bus transaction timing. `bus_addr` is set one cycle before `bus_as` rises. `bus_rd` rises one cycle after `bus_as`. Data is sampled in the cycle where `bus_rd` and `bus_rdy` are both high. Both strobes are low in the next cycle.
- R7: A fill into a line whose stored tag (address bits 23..4) differs takes the new tag and leaves only the byte just written valid in that line.
- R8: A one-cycle `flush` pulse invalidates every byte. When a flush and a fill fall in the same cycle, the flush wins and the filled byte is left invalid.
- R9: A byte request (`req_word`=0) returns its byte in `rsp_data[7:0]`, with `rsp_data[15:8]` set to zero.
- R10: `rsp_valid` is a one-cycle pulse. A `req` raised while `busy` is 1 is ignored.
- R11: During reset, `bus_as`, `bus_rd`, `rsp_valid` and `busy` are low and no byte is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | 1 enables cache lookup and fill |
| flush | input | 1 | Invalidate all cached bytes |
| req | input | 1 | Read request, taken when idle |
| req_addr | input | 24 | Request byte address |
| req_word | input | 1 | 1 = word (two bytes), 0 = byte |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | Response data valid (one cycle) |
| rsp_data | output | 16 | Response data |
| bus_addr | output | 24 | External bus address |
| bus_as | output | 1 | Address strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdy | input | 1 | Bus ready, data present |
| bus_din | input | 8 | External bus read data |

## Verification
A cache fill and a flush can fall on the same clock edge. The fill happens when the bus completes a transaction, and the flush comes from outside the block. The bench raises `flush` in exactly the cycle in which it presents `bus_rdy` for a miss. It then reads the same address again and expects a fresh bus transaction, which shows that the flush took priority. The bench also checks that the response still carries the byte that was fetched.

// File: rtl/bwrc_pkg.sv
package bwrc_pkg;
  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_LOOK = 2'd1,
    C_BUS  = 2'd2,
    C_DONE = 2'd3
  } ctrl_st_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_ADDR = 2'd1,
    B_AS   = 2'd2,
    B_RD   = 2'd3
  } bus_st_e;
endpackage

// File: rtl/bwrc_store.sv
module bwrc_store #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [BYTE_W-1:0] lk_byte,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_byte
);
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_B = 1 << OFS_W;
  localparam int TAG_W  = ADDR_W - OFS_W;

  logic [LINES-1:0][LINE_B-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [BYTE_W-1:0] data_q [LINES*LINE_B];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [OFS_W-1:0] lk_ofs, wr_ofs;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic             wr_tag_miss;

  assign lk_idx = lk_addr[OFS_W +: IDX_W];
  assign lk_ofs = lk_addr[OFS_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:OFS_W];
  assign wr_idx = wr_addr[OFS_W +: IDX_W];
  assign wr_ofs = wr_addr[OFS_W-1:0];
  assign wr_tag = wr_addr[ADDR_W-1:OFS_W];

  assign lk_hit  = valid_q[lk_idx][lk_ofs] && (tag_q[lk_idx] == lk_tag);
  assign lk_byte = data_q[{lk_idx, lk_ofs}];
  assign wr_tag_miss = (tag_q[wr_idx] != wr_tag);

  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = '0;
    end else if (wr_en) begin
      if (wr_tag_miss) valid_d[wr_idx] = '0;
      valid_d[wr_idx][wr_ofs] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_tag
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == IDX_W'(g))) tag_q[g] <= wr_tag;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) data_q[{wr_idx, wr_ofs}] <= wr_byte;
  end

  a_r3_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)][$past(wr_ofs)]);

  a_r7_retag_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && wr_tag_miss) |=> ($countones(valid_q[$past(wr_idx)]) == 1));

  a_r8_flush_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(valid_q) == 0));
endmodule

// File: rtl/bwrc_bus.sv
module bwrc_bus
  import bwrc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              done,
  output logic [BYTE_W-1:0] done_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as,
  output logic              bus_rd,
  input  logic              bus_rdy,
  input  logic [BYTE_W-1:0] bus_din
);
  bus_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    st_d    = st_q;
    addr_en = 1'b0;
    addr_d  = start_addr;
    unique case (st_q)
      B_IDLE: if (start) begin
        st_d    = B_ADDR;
        addr_en = 1'b1;
      end
      B_ADDR: st_d = B_AS;
      B_AS:   st_d = B_RD;
      B_RD:   if (bus_rdy) st_d = B_IDLE;
      default: st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_as    = (st_q == B_AS) || (st_q == B_RD);
  assign bus_rd    = (st_q == B_RD);
  assign done      = bus_rd && bus_rdy;
  assign done_byte = bus_din;

  a_r6_rd_within_as: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_as);

  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |-> $stable(bus_addr));

  a_r6_release_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_rdy) |=> (!bus_as && !bus_rd));
endmodule

// File: rtl/bwrc_ctrl.sv
module bwrc_ctrl
  import bwrc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cache_en,
  input  logic                req,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_word,
  output logic                busy,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_data,
  output logic [ADDR_W-1:0]   lk_addr,
  input  logic                lk_hit,
  input  logic [BYTE_W-1:0]   lk_byte,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [BYTE_W-1:0]   wr_byte,
  output logic                bs_start,
  output logic [ADDR_W-1:0]   bs_addr,
  input  logic                bs_done,
  input  logic [BYTE_W-1:0]   bs_byte
);
  ctrl_st_e            st_q, st_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                word_q, word_d;
  logic                ph_q, ph_d;
  logic [BYTE_W-1:0]   lo_q, lo_d;
  logic [2*BYTE_W-1:0] out_q, out_d;
  logic [ADDR_W-1:0]   cur_addr;
  logic                take;
  logic [BYTE_W-1:0]   take_byte;

  assign cur_addr = addr_q + ADDR_W'(ph_q);
  assign lk_addr  = cur_addr;
  assign bs_addr  = cur_addr;
  assign wr_addr  = cur_addr;
  assign wr_byte  = bs_byte;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    word_d    = word_q;
    ph_d      = ph_q;
    lo_d      = lo_q;
    out_d     = out_q;
    bs_start  = 1'b0;
    wr_en     = 1'b0;
    take      = 1'b0;
    take_byte = lk_byte;
    unique case (st_q)
      C_IDLE: if (req) begin
        addr_d = req_addr;
        word_d = req_word;
        ph_d   = 1'b0;
        st_d   = C_LOOK;
      end
      C_LOOK: begin
        if (cache_en && lk_hit) begin
          take = 1'b1;
        end else begin
          bs_start = 1'b1;
          st_d     = C_BUS;
        end
      end
      C_BUS: if (bs_done) begin
        wr_en     = cache_en;
        take      = 1'b1;
        take_byte = bs_byte;
      end
      C_DONE: st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
    if (take) begin
      if (!ph_q) begin
        lo_d = take_byte;
        if (word_q) begin
          ph_d = 1'b1;
          st_d = C_LOOK;
        end else begin
          out_d = {{BYTE_W{1'b0}}, take_byte};
          st_d  = C_DONE;
        end
      end else begin
        out_d = {take_byte, lo_q};
        st_d  = C_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      addr_q <= '0;
      word_q <= 1'b0;
      ph_q   <= 1'b0;
      lo_q   <= '0;
      out_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      word_q <= word_d;
      ph_q   <= ph_d;
      lo_q   <= lo_d;
      out_q  <= out_d;
    end
  end

  assign busy      = (st_q != C_IDLE);
  assign rsp_valid = (st_q == C_DONE);
  assign rsp_data  = out_q;

  a_r10_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_busy_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && req) |-> $stable(addr_q));
endmodule

// File: rtl/byte_word_rcache.sv
module byte_word_rcache #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cache_en,
  input  logic                flush,
  input  logic                req,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_word,
  output logic                busy,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_data,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_as,
  output logic                bus_rd,
  input  logic                bus_rdy,
  input  logic [BYTE_W-1:0]   bus_din
);
  logic [ADDR_W-1:0] lk_addr, wr_addr, bs_addr;
  logic              lk_hit, wr_en, bs_start, bs_done;
  logic [BYTE_W-1:0] lk_byte, wr_byte, bs_byte;

  bwrc_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
    .req(req), .req_addr(req_addr), .req_word(req_word),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_byte(lk_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .bs_start(bs_start), .bs_addr(bs_addr), .bs_done(bs_done), .bs_byte(bs_byte)
  );

  bwrc_store #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_byte(lk_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  bwrc_bus #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bs_start), .start_addr(bs_addr),
    .done(bs_done), .done_byte(bs_byte),
    .bus_addr(bus_addr), .bus_as(bus_as), .bus_rd(bus_rd),
    .bus_rdy(bus_rdy), .bus_din(bus_din)
  );

  a_r4_hit_keeps_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_en && lk_hit && busy && !bus_as && !bs_start) |=> !bus_as);

  a_r5_no_fill_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_en |-> !wr_en);
endmodule

// File: tb/sim_byte_word_rcache.sv
module sim_byte_word_rcache;
  logic        clk, rst_n, cache_en, flush, req, req_word;
  logic [23:0] req_addr;
  logic        busy, rsp_valid;
  logic [15:0] rsp_data;
  logic [23:0] bus_addr;
  logic        bus_as, bus_rd, bus_rdy;
  logic [7:0]  bus_din;

  int nvec = 0;
  int nerr = 0;
  int ntx = 0;
  logic [23:0] txa [0:7];
  logic flush_on_rdy = 1'b0;
  logic finished = 1'b0;

  byte_word_rcache u0 (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
    .req(req), .req_addr(req_addr), .req_word(req_word),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_addr(bus_addr), .bus_as(bus_as), .bus_rd(bus_rd),
    .bus_rdy(bus_rdy), .bus_din(bus_din)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mem(input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd13;
    return m ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus slave: two wait cycles after read strobe, protocol checks (R6)
  initial begin
    logic       prev_as = 1'b0;
    logic [23:0] prev_addr = '0;
    logic       rdy_given = 1'b0;
    int         wcnt = 0;
    bus_rdy = 1'b0;
    bus_din = '0;
    flush = 1'b0;
    forever begin
      @(negedge clk);
      flush = 1'b0;
      if (rst_n) begin
        if (bus_as && !prev_as) begin
          chk(bus_addr == prev_addr && !bus_rd, "R6 addr before strobe", bus_addr, prev_addr);
          if (ntx < 8) txa[ntx] = bus_addr;
          ntx++;
        end
        if (rdy_given)
          chk(!bus_as && !bus_rd, "R6 strobes released", {bus_as, bus_rd}, 0);
      end
      rdy_given = 1'b0;
      if (bus_rd && !bus_rdy) begin
        if (wcnt == 2) begin
          bus_rdy = 1'b1;
          bus_din = mem(bus_addr);
          rdy_given = 1'b1;
          if (flush_on_rdy) flush = 1'b1;
          wcnt = 0;
        end else wcnt++;
      end else begin
        bus_rdy = 1'b0;
        bus_din = '0;
        wcnt = 0;
      end
      prev_as = bus_as;
      prev_addr = bus_addr;
    end
  end

  task automatic do_read(input logic [23:0] a, input logic w, output logic [15:0] d);
    int t;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_word = w;
    @(negedge clk);
    req = 1'b0;
    t = 0;
    while (!rsp_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(rsp_valid, "R10 response arrives", rsp_valid, 1);
    d = rsp_data;
    @(negedge clk);
    chk(!rsp_valid, "R10 single-cycle response", rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk(!bus_as && !bus_rd && !rsp_valid && !busy, "R11 reset outputs",
        {bus_as, bus_rd, rsp_valid, busy}, 0);
  endtask

  task automatic t_word_miss();
    logic [15:0] d;
    ntx = 0;
    do_read(24'h001004, 1'b1, d);
    chk(ntx == 2, "R1 two transactions", ntx, 2);
    chk(txa[0] == 24'h001004 && txa[1] == 24'h001005, "R1 order", {txa[0][15:0], txa[1][15:0]}, 32'h10041005);
    chk(d == {mem(24'h001005), mem(24'h001004)}, "R2 word assembly", d, {mem(24'h001005), mem(24'h001004)});
  endtask

  task automatic t_word_hit();
    logic [15:0] d;
    ntx = 0;
    do_read(24'h001004, 1'b1, d);
    chk(ntx == 0, "R4 word hit no bus", ntx, 0);
    chk(d == {mem(24'h001005), mem(24'h001004)}, "R3 both cached bytes true", d, {mem(24'h001005), mem(24'h001004)});
    do_read(24'h001005, 1'b0, d);
    chk(ntx == 0, "R4 byte hit no bus", ntx, 0);
    chk(d == {8'h00, mem(24'h001005)}, "R9 byte response", d, {8'h00, mem(24'h001005)});
  endtask

  task automatic t_partial();
    logic [15:0] d;
    ntx = 0;
    do_read(24'h002008, 1'b0, d);
    chk(ntx == 1, "R3 byte miss one txn", ntx, 1);
    ntx = 0;
    do_read(24'h002008, 1'b1, d);
    chk(ntx == 1 && txa[0] == 24'h002009, "R3 neighbour still invalid", txa[0], 24'h002009);
    chk(d == {mem(24'h002009), mem(24'h002008)}, "R2 mixed hit/miss word", d, {mem(24'h002009), mem(24'h002008)});
  endtask

  task automatic t_disable();
    logic [15:0] d;
    cache_en = 1'b0;
    ntx = 0;
    do_read(24'h001004, 1'b1, d);
    chk(ntx == 2, "R5 disabled goes to bus", ntx, 2);
    chk(d == {mem(24'h001005), mem(24'h001004)}, "R5 disabled data", d, {mem(24'h001005), mem(24'h001004)});
    ntx = 0;
    do_read(24'h003000, 1'b0, d);
    cache_en = 1'b1;
    do_read(24'h003000, 1'b0, d);
    chk(ntx == 2, "R5 no fill while disabled", ntx, 2);
  endtask

  task automatic t_retag();
    logic [15:0] d;
    ntx = 0;
    do_read(24'h011006, 1'b0, d);
    do_read(24'h011006, 1'b0, d);
    chk(ntx == 1, "R7 new tag filled then hit", ntx, 1);
    chk(d == {8'h00, mem(24'h011006)}, "R7 new tag data", d, {8'h00, mem(24'h011006)});
    ntx = 0;
    do_read(24'h001004, 1'b0, d);
    chk(ntx == 1, "R7 old tag evicted", ntx, 1);
    ntx = 0;
    do_read(24'h011006, 1'b0, d);
    chk(ntx == 1, "R7 other bytes cleared on retag", ntx, 1);
  endtask

  task automatic t_flush();
    logic [15:0] d;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    ntx = 0;
    do_read(24'h011006, 1'b0, d);
    chk(ntx == 1, "R8 flush invalidates", ntx, 1);
    flush_on_rdy = 1'b1;
    ntx = 0;
    do_read(24'h004000, 1'b0, d);
    flush_on_rdy = 1'b0;
    chk(d == {8'h00, mem(24'h004000)}, "R8 data during flush", d, {8'h00, mem(24'h004000)});
    do_read(24'h004000, 1'b0, d);
    chk(ntx == 2, "R8 flush beats fill", ntx, 2);
  endtask

  task automatic t_busy();
    int t;
    int nr;
    ntx = 0;
    @(negedge clk);
    req = 1'b1; req_addr = 24'h005010; req_word = 1'b0;
    @(negedge clk);
    req_addr = 24'h006020; req_word = 1'b1;
    nr = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        nr++;
        req = 1'b0;
      end
    end
    req = 1'b0;
    t = 0;
    while (busy && t < 50) begin @(negedge clk); t++; end
    chk(ntx == 1 && txa[0] == 24'h005010, "R10 request while busy ignored", txa[0], 24'h005010);
    chk(nr == 1, "R10 one response", nr, 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nerr++;
      nvec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cache_en = 1'b1; req = 1'b0; req_word = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_word_miss();
    t_word_hit();
    t_partial();
    t_disable();
    t_retag();
    t_flush();
    t_busy();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule